// File: doc/BRIEF.md
# General Register File with Constant-Zero Entry and Return-Address Entry

This block holds the architectural integer registers of a small load/store processor: 32 entries of 32 bits each, selected by 5-bit register numbers. Two read ports deliver operand values combinationally from their addresses. One write port stores a result on the rising clock edge when its enable is high. The decode and execute logic drives these ports directly.

Two entries are special. Entry 0 is a constant zero: it always reads as 0, and writes addressed to it are dropped. Entry 31 can also be loaded through a dedicated return-address path used by a jump-and-link operation. That path takes the current program counter and stores that value plus 4, with no destination number supplied. When both the return-address path and the normal port target entry 31 in the same cycle, the return-address path wins. Every other entry behaves the same.

Reads see the stored contents only. A read of an entry in the same cycle it is written returns the value held before that edge, because there is no internal bypass. A synchronous active-low reset clears entries 1 to 31.

Top module: `regfile_zl`

## Requirements
- R1: Two read ports operate independently and combinationally: each data output shows the content of the entry its 5-bit address selects, without waiting for a clock edge.
- R2: Entry 0 always reads as 0 on both ports, and a write with address 0 changes no entry.
- R3: When `wr_en` is 1 at a rising clock edge, `wr_data` is stored in the entry numbered by `wr_addr`, for any address 1 to 31, including 31 when the return-address path is idle.
- R4: When `link_en` is 1 at a rising clock edge, entry 31 receives `link_pc + 4`, with the sum taken modulo 2^32.
- R5: If `link_en` is 1 and the normal port writes address 31 at the same edge, entry 31 takes `link_pc + 4`. A normal write to any other address at that edge still completes.
- R6: A read of an entry that is being written in the same cycle returns the value held before that edge. The new value appears only after the edge.
- R7: When `wr_en` and `link_en` are both 0 at an edge, no entry changes, whatever `wr_addr`, `wr_data` and `link_pc` carry.
- R8: When `rst_n` is 0 at a rising edge, entries 1 to 31 become 0, and any write or return-address request at that edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of the entry selected on port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of the entry selected on port B |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 5 | Destination register number for the normal write |
| wr_data | input | 32 | Value for the normal write |
| link_en | input | 1 | Return-address write request for entry 31 |
| link_pc | input | 32 | Program counter of the jump-and-link; entry 31 receives this plus 4 |

## Verification
On every cycle, the assertions check the following. Address 0 reads as zero on both ports. An enabled normal write lands in its entry on the next edge. A return-address request loads entry 31 with the incremented PC, and that request wins an address-31 collision. Idle cycles leave the whole array stable.

Some behaviours only the directed scenarios can show. These are the old-value result of a read that coincides with a write, reset clearing every entry even while writes are requested, and the two read ports selecting different entries at once. The scenarios also show the wrap of the PC sum at the top of the 32-bit range, and that the normal port still completes a write elsewhere in a cycle where a return-address write also occurs.

// File: rtl/rf_pkg.sv
// Package rf_pkg
// Shared default geometry for the register file and its sub-blocks.
// Assumes: the register count is a power of two set by the address width.
package rf_pkg;
    localparam int RF_DATA_W  = 32;
    localparam int RF_ADDR_W  = 5;
    localparam int RF_PC_STEP = 4;
endpackage

// File: rtl/rf_write_steer.sv
// Module rf_write_steer
// Turns the normal write port and the return-address request into a
// per-entry write enable and a per-entry write value for entries 1..N-1.
// Entry 0 has no lane, so nothing can ever be steered into it.
// Assumes: the return-address entry is the highest-numbered entry.
module rf_write_steer #(
    parameter int DATA_W  = rf_pkg::RF_DATA_W,
    parameter int ADDR_W  = rf_pkg::RF_ADDR_W,
    parameter int PC_STEP = rf_pkg::RF_PC_STEP,
    localparam int NUM_REGS = 1 << ADDR_W,
    localparam int LINK_IDX = NUM_REGS - 1
) (
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 link_en,
    input  logic [DATA_W-1:0]                    link_pc,
    output logic [NUM_REGS-1:1]                  lane_we,
    output logic [NUM_REGS-1:1][DATA_W-1:0]      lane_wd
);

    logic [DATA_W-1:0] ret_addr;

    // Return address: program counter advanced by one instruction.
    always_comb ret_addr = link_pc + DATA_W'(PC_STEP);

    for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_lane
        logic hit;
        // Decode of the normal destination for this entry.
        always_comb hit = wr_en && (wr_addr == ADDR_W'(gi));
        if (gi == LINK_IDX) begin : g_link
            // Return-address lane: the link request overrides a normal hit.
            always_comb begin
                lane_we[gi] = hit | link_en;
                lane_wd[gi] = link_en ? ret_addr : wr_data;
            end
        end else begin : g_plain
            // Ordinary lane: only the normal port can write here.
            always_comb begin
                lane_we[gi] = hit;
                lane_wd[gi] = wr_data;
            end
        end
    end

endmodule

// File: rtl/rf_storage.sv
// Module rf_storage
// Holds the entries. Entry 0 is a constant zero with no flops; entries
// 1..N-1 load their lane value on a rising edge when their lane enable
// is set, and clear on a synchronous active-low reset.
// Assumes: the steering block guarantees a consistent lane value.
module rf_storage #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_REGS-1:1]                  lane_we,
    input  logic [NUM_REGS-1:1][DATA_W-1:0]      lane_wd,
    output logic [NUM_REGS-1:0][DATA_W-1:0]      entries
);

    // Constant-zero entry: no storage behind it.
    always_comb entries[0] = '0;

    for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_entry
        // One entry: clear on reset, otherwise load when its lane is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[gi] <= '0;
            end else if (lane_we[gi]) begin
                entries[gi] <= lane_wd[gi];
            end
        end
    end

endmodule

// File: rtl/rf_read_port.sv
// Module rf_read_port
// One combinational read port: selects an entry by number. There is no
// bypass, so a value being written this cycle is not visible until after
// the edge.
// Assumes: entry 0 of the input array is already held at zero.
module rf_read_port #(
    parameter int DATA_W = rf_pkg::RF_DATA_W,
    parameter int ADDR_W = rf_pkg::RF_ADDR_W,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]      entries,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [DATA_W-1:0]                    rd_data
);

    // Plain selection from the stored contents.
    always_comb rd_data = entries[rd_addr];

endmodule

// File: rtl/regfile_zl.sv
// Module regfile_zl
// Register file with two combinational read ports, one synchronous write
// port, a constant-zero entry 0 and a return-address write path that
// targets the highest entry. The return-address path wins a collision at
// that entry. Synchronous active-low reset clears every stored entry.
// Assumes: callers need no same-cycle bypass from write to read.
module regfile_zl #(
    parameter int DATA_W  = rf_pkg::RF_DATA_W,
    parameter int ADDR_W  = rf_pkg::RF_ADDR_W,
    parameter int PC_STEP = rf_pkg::RF_PC_STEP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [DATA_W-1:0] link_pc
);

    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int LINK_IDX = NUM_REGS - 1;

    logic [NUM_REGS-1:1]             lane_we;
    logic [NUM_REGS-1:1][DATA_W-1:0] lane_wd;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    rf_write_steer #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PC_STEP(PC_STEP)
    ) u_steer (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .link_en(link_en),
        .link_pc(link_pc),
        .lane_we(lane_we),
        .lane_wd(lane_wd)
    );

    rf_storage #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_we(lane_we),
        .lane_wd(lane_wd),
        .entries(regs_q)
    );

    rf_read_port #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_rd_a (
        .entries(regs_q),
        .rd_addr(rd_addr_a),
        .rd_data(rd_data_a)
    );

    rf_read_port #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_rd_b (
        .entries(regs_q),
        .rd_addr(rd_addr_b),
        .rd_data(rd_data_b)
    );

    // Zero entry reads as zero on both ports.
    AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0)); // R2
    AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0)); // R2

    // An enabled normal write without a collision lands on the next edge.
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != '0) && !(link_en && (wr_addr == ADDR_W'(LINK_IDX))))
        |=> (regs_q[$past(wr_addr)] == $past(wr_data))); // R3

    // A return-address request loads the incremented PC.
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> (regs_q[LINK_IDX] == ($past(link_pc) + DATA_W'(PC_STEP)))); // R4

    // On a collision at the link entry the normal data is not what lands.
    AST_LINK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en && wr_en && (wr_addr == ADDR_W'(LINK_IDX)) &&
         (wr_data != (link_pc + DATA_W'(PC_STEP))))
        |=> (regs_q[LINK_IDX] != $past(wr_data))); // R5

    // Idle cycles leave the whole array untouched.
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !link_en) |=> $stable(regs_q)); // R7

endmodule

// File: tb/test_regfile_zl.sv
`timescale 1ns/1ps
module test_regfile_zl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
    logic [31:0] rd_data_a, rd_data_b, wr_data, link_pc;
    logic        wr_en, link_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    regfile_zl i_regfile_zl (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_en(link_en), .link_pc(link_pc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Advance across one rising edge; inputs change at falling edges.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; link_en = 1'b0;
        wr_addr = '0; wr_data = '0; link_pc = '0;
    endtask

    // Read one entry on both ports and compare with the model.
    task automatic read_both(input string req, input int idx);
        rd_addr_a = 5'(idx);
        rd_addr_b = 5'(31 - idx);
        #1;
        chk(req, $sformatf("port A entry %0d", idx), rd_data_a, model[idx]);
        chk(req, $sformatf("port B entry %0d", 31 - idx), rd_data_b, model[31 - idx]);
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 32; i++) model[i] = '0;
        for (int i = 0; i < 32; i++) read_both("R8", i);
    endtask

    task automatic t_fill_all();
        for (int i = 1; i < 32; i++) begin
            wr_en = 1'b1; wr_addr = 5'(i); wr_data = 32'hA5000000 ^ (32'(i) * 32'h01010101);
            model[i] = wr_data;
            tick();
        end
        idle_inputs();
        for (int i = 0; i < 32; i++) read_both("R3", i);
        // R1: ports change with address alone, no edge in between.
        rd_addr_a = 5'd3; rd_addr_b = 5'd17; #1;
        chk("R1", "port A follows address", rd_data_a, model[3]);
        chk("R1", "port B follows address", rd_data_b, model[17]);
    endtask

    task automatic t_zero_write();
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hDEADBEEF;
        tick();
        idle_inputs();
        for (int i = 0; i < 32; i++) read_both("R2", i);
    endtask

    task automatic t_link_basic();
        link_en = 1'b1; link_pc = 32'h00001004;
        tick();
        idle_inputs();
        model[31] = 32'h00001008;
        rd_addr_a = 5'd31; #1;
        chk("R4", "link value", rd_data_a, model[31]);
        link_en = 1'b1; link_pc = 32'hFFFFFFFE;
        tick();
        idle_inputs();
        model[31] = 32'h00000002;
        #1;
        chk("R4", "link value wraps", rd_data_a, model[31]);
    endtask

    task automatic t_link_priority();
        link_en = 1'b1; link_pc = 32'h00400020;
        wr_en = 1'b1; wr_addr = 5'd31; wr_data = 32'h12345678;
        tick();
        model[31] = 32'h00400024;
        link_en = 1'b1; link_pc = 32'h00400100;
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hCAFEF00D;
        tick();
        idle_inputs();
        model[31] = 32'h00400104;
        model[5]  = 32'hCAFEF00D;
        rd_addr_a = 5'd31; rd_addr_b = 5'd5; #1;
        chk("R5", "link wins entry 31", rd_data_a, model[31]);
        chk("R5", "other write completes", rd_data_b, model[5]);
    endtask

    task automatic t_read_during_write();
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h77777777;
        rd_addr_a = 5'd7; rd_addr_b = 5'd7;
        #1;
        chk("R6", "port A before edge", rd_data_a, model[7]);
        chk("R6", "port B before edge", rd_data_b, model[7]);
        tick();
        idle_inputs();
        model[7] = 32'h77777777;
        #1;
        chk("R6", "port A after edge", rd_data_a, model[7]);
    endtask

    task automatic t_idle_no_effect();
        wr_en = 1'b0; link_en = 1'b0;
        wr_addr = 5'd9; wr_data = 32'hBADBAD00; link_pc = 32'h0BAD0BAD;
        tick(); tick();
        idle_inputs();
        for (int i = 0; i < 32; i++) read_both("R7", i);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h99999999;
        link_en = 1'b1; link_pc = 32'h100;
        tick();
        rst_n = 1'b1;
        idle_inputs();
        for (int i = 0; i < 32; i++) model[i] = '0;
        for (int i = 0; i < 32; i++) read_both("R8", i);
    endtask

    initial begin
        rst_n = 1'b0;
        rd_addr_a = '0; rd_addr_b = '0;
        idle_inputs();
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        t_reset_state();
        t_fill_all();
        t_zero_write();
        t_link_basic();
        t_link_priority();
        t_read_during_write();
        t_idle_no_effect();
        t_reset_again();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule